// File: doc/BRIEF.md
# Pattern-Row Opcode Timing Decoder

This block is the control core of a small 8-bit processor whose opcodes are single bytes. After a fetch cycle it holds the opcode in a register and counts execution cycles from zero. A fixed array of pattern rows is compared against the opcode and the cycle count. Each row is a mask, a value and a cycle slot, and it names one control action. A row fires when the opcode ANDed with its mask equals its value and the count equals its slot. Every row that fires drives its action in that cycle. No row wins over another, so several actions can happen in the same cycle.

There are four actions:
- operand: read the byte at the program counter onto an internal bus and advance the counter.
- load-A: copy the bus into the accumulator.
- load-X: copy the bus into the X register.
- next: return to the fetch cycle.

The rows are:

| Action | Mask | Value | Slot |
|---|---|---|---|
| operand | 0xF0 | 0xA0 | 0 |
| load-A | 0xF1 | 0xA1 | 1 |
| load-X | 0xF2 | 0xA2 | 1 |
| next | 0xF0 | 0xA0 | 2 |

The three intended opcodes decode as follows:
- 0xA9 loads the accumulator.
- 0xA2 loads X.
- 0xAF, which was never meant to be used, loads both.

An opcode that matches no next row runs out of slots and halts. The core then stays halted until reset. A bus register, an accumulator and an X register are included so that each instruction has a visible effect.

Top module: `rowmatch_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released: mem_addr_o is 0, acc_o is 0, xreg_o is 0 and halted_o is 0.
- R2: The fetch cycle latches mem_rdata_i as the opcode and advances the address by one. In the execute cycle whose slot is 0, an operand-matching opcode (opcode & 0xF0 == 0xA0) reads the operand at the current address, and the address then advances by one again.
- R3: Opcode 0xA9 loads its operand byte into acc_o and leaves xreg_o unchanged.
- R4: Opcode 0xA2 loads its operand byte into xreg_o and leaves acc_o unchanged.
- R5: Opcodes 0xAF and 0xA3 match both load rows. They load the same operand byte into acc_o and xreg_o in the same cycle.
- R6: Opcode 0xA0 matches only the operand row and the next row. It consumes one operand byte and changes neither acc_o nor xreg_o. Opcode 0xA1 loads acc_o only.
- R7: An opcode that matches no next row, for example 0x00, sets halted_o four cycles after its fetch cycle. From then on halted_o, mem_addr_o, acc_o and xreg_o hold until reset. Opcode 0x00 also matches no operand row, so the address stays one past the opcode.
- R8: Asserting reset after a halt clears halted_o and restarts execution from address 0.
- R9: A matching instruction takes four cycles: fetch, slot 0, slot 1 and slot 2. The register load becomes visible three cycles after the fetch cycle, and the next fetch comes four cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata_i | input | 8 | Byte read from memory at mem_addr_o, same cycle |
| mem_addr_o | output | 8 | Program counter, used as the memory read address |
| halted_o | output | 1 | High once an opcode ran past the last slot without a next row |
| acc_o | output | 8 | Accumulator contents |
| xreg_o | output | 8 | X register contents |

## Verification
Index k counts the cycles after reset release, so index 0 is the first fetch. With 2-byte instructions, fetch k falls on index 4k at address 2k. A load becomes visible at index 4k+3. A halting opcode fetched at index i raises halted_o at index i+4.

The scoreboard is filled in advance with expected values tagged by cycle index. The monitor counts falling edges from the release of reset and compares each entry only on the edge whose index matches. Every sample therefore falls halfway between rising edges, after all registers on the path have updated.

// File: rtl/rowmatch_pkg.sv
package rowmatch_pkg;

    localparam int OPC_W     = 8;
    localparam int NUM_ROWS  = 4;
    localparam int NUM_ACTS  = 4;
    localparam int LAST_SLOT = 2;
    localparam int CYC_W     = $clog2(LAST_SLOT + 2);
    localparam int ACT_W     = $clog2(NUM_ACTS);

    localparam int ACT_OPERAND = 0;
    localparam int ACT_LOAD_A  = 1;
    localparam int ACT_LOAD_X  = 2;
    localparam int ACT_NEXT    = 3;

    typedef struct packed {
        logic [OPC_W-1:0] mask;
        logic [OPC_W-1:0] value;
        logic [CYC_W-1:0] slot;
        logic [ACT_W-1:0] act;
    } row_t;

    function automatic row_t row_at(input int idx);
        row_t r;
        case (idx)
            0:       r = '{mask: 8'hF0, value: 8'hA0, slot: CYC_W'(0), act: ACT_W'(ACT_OPERAND)};
            1:       r = '{mask: 8'hF1, value: 8'hA1, slot: CYC_W'(1), act: ACT_W'(ACT_LOAD_A)};
            2:       r = '{mask: 8'hF2, value: 8'hA2, slot: CYC_W'(1), act: ACT_W'(ACT_LOAD_X)};
            default: r = '{mask: 8'hF0, value: 8'hA0, slot: CYC_W'(LAST_SLOT), act: ACT_W'(ACT_NEXT)};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rowmatch_array.sv
module rowmatch_array
    import rowmatch_pkg::*;
(
    input  logic [OPC_W-1:0]    opcode_i,
    input  logic [CYC_W-1:0]    cyc_i,
    input  logic                exec_i,
    output logic [NUM_ACTS-1:0] strobe_o
);

    logic [NUM_ROWS-1:0] hit;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        localparam row_t ROW = row_at(r);
        assign hit[r] = exec_i
                     && ((opcode_i & ROW.mask) == ROW.value)
                     && (cyc_i == ROW.slot);
    end

    always_comb begin
        strobe_o = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (hit[r]) begin
                strobe_o[row_at(r).act] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rowmatch_seq.sv
module rowmatch_seq
    import rowmatch_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  fetch_byte_i,
    input  logic              operand_i,
    input  logic              next_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [OPC_W-1:0]  opcode_o,
    output logic [CYC_W-1:0]  cyc_o,
    output logic              exec_o,
    output logic              halted_o
);

    localparam logic [CYC_W-1:0] SLOT_END = CYC_W'(LAST_SLOT);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [OPC_W-1:0]  opcode;
        logic [CYC_W-1:0]  cyc;
        logic              fetch;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.fetch) begin
            st_d.opcode = fetch_byte_i;
            st_d.pc     = st_q.pc + ADDR_W'(1);
            st_d.cyc    = '0;
            st_d.fetch  = 1'b0;
        end else begin
            if (operand_i) begin
                st_d.pc = st_q.pc + ADDR_W'(1);
            end
            if (next_i) begin
                st_d.fetch = 1'b1;
                st_d.cyc   = '0;
            end else if (st_q.cyc <= SLOT_END) begin
                st_d.cyc = st_q.cyc + CYC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pc: '0, opcode: '0, cyc: '0, fetch: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o     = st_q.pc;
    assign opcode_o = st_q.opcode;
    assign cyc_o    = st_q.cyc;
    assign exec_o   = !st_q.fetch;
    assign halted_o = !st_q.fetch && (st_q.cyc > SLOT_END);

    AST_FETCH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |=> pc_o == $past(pc_o) + ADDR_W'(1)); // R2
    AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |=> exec_o && cyc_o == '0); // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o); // R7
    AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> $stable(pc_o)); // R7

endmodule

// File: rtl/rowmatch_dp.sv
module rowmatch_dp #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              ld_bus_i,
    input  logic              ld_a_i,
    input  logic              ld_x_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] xreg_o
);

    typedef struct packed {
        logic [DATA_W-1:0] bus;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] xr;
    } dp_state_t;

    dp_state_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (ld_bus_i) dp_d.bus = rdata_i;
        if (ld_a_i)   dp_d.acc = dp_q.bus;
        if (ld_x_i)   dp_d.xr  = dp_q.bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign acc_o  = dp_q.acc;
    assign xreg_o = dp_q.xr;

    AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_a_i |=> $stable(acc_o)); // R4
    AST_XREG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_x_i |=> $stable(xreg_o)); // R3
    AST_DUAL_LOAD_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a_i && ld_x_i) |=> acc_o == xreg_o); // R5

endmodule

// File: rtl/rowmatch_core.sv
module rowmatch_core
    import rowmatch_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              halted_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] xreg_o
);

    logic [OPC_W-1:0]    opcode;
    logic [CYC_W-1:0]    cyc;
    logic                exec;
    logic [NUM_ACTS-1:0] strobe;

    rowmatch_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_byte_i (mem_rdata_i[OPC_W-1:0]),
        .operand_i    (strobe[ACT_OPERAND]),
        .next_i       (strobe[ACT_NEXT]),
        .pc_o         (mem_addr_o),
        .opcode_o     (opcode),
        .cyc_o        (cyc),
        .exec_o       (exec),
        .halted_o     (halted_o)
    );

    rowmatch_array u_array (
        .opcode_i (opcode),
        .cyc_i    (cyc),
        .exec_i   (exec),
        .strobe_o (strobe)
    );

    rowmatch_dp #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdata_i  (mem_rdata_i),
        .ld_bus_i (strobe[ACT_OPERAND]),
        .ld_a_i   (strobe[ACT_LOAD_A]),
        .ld_x_i   (strobe[ACT_LOAD_X]),
        .acc_o    (acc_o),
        .xreg_o   (xreg_o)
    );

    AST_HALT_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> $stable(acc_o) && $stable(xreg_o)); // R7

endmodule

// File: tb/sim_rowmatch_core.sv
module sim_rowmatch_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rdata;
    logic [7:0] addr;
    logic       halted;
    logic [7:0] acc, xreg;

    logic [7:0] mem [256];

    always #2 clk = ~clk;

    assign rdata = mem[addr];

    rowmatch_core u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_rdata_i (rdata),
        .mem_addr_o  (addr),
        .halted_o    (halted),
        .acc_o       (acc),
        .xreg_o      (xreg)
    );

    typedef struct {
        int         idx;
        logic [7:0] addr;
        logic [7:0] a;
        logic [7:0] x;
        logic       h;
        string      req;
    } exp_t;

    exp_t sb[$];
    exp_t e;
    int   checks = 0;
    int   fails  = 0;
    int   cnt    = 0;
    bit   mon_en = 1'b0;
    bit   done   = 1'b0;

    task automatic expect_at(input int idx, input logic [7:0] ad, input logic [7:0] a,
                             input logic [7:0] x, input logic h, input string req);
        exp_t n;
        n.idx = idx; n.addr = ad; n.a = a; n.x = x; n.h = h; n.req = req;
        sb.push_back(n);
    endtask

    task automatic compare(input string req, input logic [7:0] ad, input logic [7:0] a,
                           input logic [7:0] x, input logic h);
        checks++;
        if (addr !== ad || acc !== a || xreg !== x || halted !== h) begin
            fails++;
            $display("FAIL %s @idx %0d: addr=%h acc=%h x=%h halt=%b expected addr=%h acc=%h x=%h halt=%b",
                     req, cnt, addr, acc, xreg, halted, ad, a, x, h);
        end
    endtask

    // monitor: samples at the falling edge, compares entries due at this index
    always @(negedge clk) begin
        if (mon_en) begin
            while (sb.size() > 0 && sb[0].idx == cnt) begin
                e = sb.pop_front();
                compare(e.req, e.addr, e.a, e.x, e.h);
            end
            cnt = cnt + 1;
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[0]  = 8'hA9; mem[1]  = 8'h11;
        mem[2]  = 8'hA2; mem[3]  = 8'h22;
        mem[4]  = 8'hAF; mem[5]  = 8'h33;
        mem[6]  = 8'hA0; mem[7]  = 8'h44;
        mem[8]  = 8'hA1; mem[9]  = 8'h55;
        mem[10] = 8'hA3; mem[11] = 8'h66;
        mem[12] = 8'h00; mem[13] = 8'h77;

        // phase 1: program run ending in a halt
        expect_at(0,  8'd0,  8'h00, 8'h00, 1'b0, "R1");
        expect_at(1,  8'd1,  8'h00, 8'h00, 1'b0, "R2");
        expect_at(2,  8'd2,  8'h00, 8'h00, 1'b0, "R9");
        expect_at(3,  8'd2,  8'h11, 8'h00, 1'b0, "R9");
        expect_at(4,  8'd2,  8'h11, 8'h00, 1'b0, "R3");
        expect_at(8,  8'd4,  8'h11, 8'h22, 1'b0, "R4");
        expect_at(12, 8'd6,  8'h33, 8'h33, 1'b0, "R5");
        expect_at(16, 8'd8,  8'h33, 8'h33, 1'b0, "R6");
        expect_at(20, 8'd10, 8'h55, 8'h33, 1'b0, "R6");
        expect_at(24, 8'd12, 8'h66, 8'h66, 1'b0, "R5");
        expect_at(27, 8'd13, 8'h66, 8'h66, 1'b0, "R7");
        expect_at(28, 8'd13, 8'h66, 8'h66, 1'b1, "R7");
        expect_at(40, 8'd13, 8'h66, 8'h66, 1'b1, "R7");

        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 compare("R1", 8'd0, 8'h00, 8'h00, 1'b0);
        rst_n = 1'b1;
        cnt = 0;
        mon_en = 1'b1;
        repeat (45) @(posedge clk);
        #1 mon_en = 1'b0;
        while (sb.size() > 0) begin
            e = sb.pop_front();
            checks++; fails++;
            $display("FAIL %s: entry for idx %0d never compared, actual=missed expected=compared", e.req, e.idx);
        end

        // phase 2: reset out of the halt and restart
        rst_n = 1'b0;
        @(posedge clk);
        #1 compare("R8", 8'd0, 8'h00, 8'h00, 1'b0);
        expect_at(0, 8'd0, 8'h00, 8'h00, 1'b0, "R8");
        expect_at(3, 8'd2, 8'h11, 8'h00, 1'b0, "R8");
        expect_at(4, 8'd2, 8'h11, 8'h00, 1'b0, "R8");
        rst_n = 1'b1;
        cnt = 0;
        mon_en = 1'b1;
        repeat (8) @(posedge clk);
        #1 mon_en = 1'b0;
        while (sb.size() > 0) begin
            e = sb.pop_front();
            checks++; fails++;
            $display("FAIL %s: entry for idx %0d never compared, actual=missed expected=compared", e.req, e.idx);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule